// File: doc/BRIEF.md
# Host Byte-Port Window onto a Word Memory

This block gives a host with an 8-bit I/O port bus access to a 32-bit-wide internal memory through six byte registers. Two of the registers hold a word address and an access type. The other four are data lanes, one for each byte of the addressed word. The window occupies six consecutive port offsets that start at a base the integrating logic supplies on `win_base`.

The two access types behave differently.

- **Long accesses (type 10 or 11):** reading data lane 0 fetches a whole word into a staging register, and writing data lane 3 commits the staged word. With type 11 the word address then steps by one after each lane-3 access, so the host streams words by walking the lanes 0, 1, 2, 3 over and over.
- **Byte accesses (type 00 or 01):** each data access reaches memory directly for one lane. This is how the host handles misaligned or partial words.

Host requests use a valid/ready handshake. A request is accepted on a clock edge where `io_valid` and `io_ready` are both high. While it waits, the host holds `io_addr`, `io_write` and `io_wdata` stable. `io_ready` drops only while a memory fetch is in flight. Read answers come back as a one-cycle `io_rvalid` pulse with no back-pressure, so the host must take `io_rdata` in that cycle. Memory reads return data one cycle after `mem_re`.

Top module: `host_mem_window`

## Requirements
- R1: After reset, `io_ready` is 1, `mem_we`, `mem_re` and `io_rvalid` are 0, and both address registers read back as 0x00.
- R2: Only offsets 0 to 5 from `win_base` are decoded. Any other port address is accepted but changes nothing and issues no memory strobe, and a read of it answers 0x00. Changing `win_base` moves the window.
- R3: Offset 0 holds the word address bits 5:0 in its bits 7:2 and the access type in bits 1:0. Offset 1 holds the word address bits 12:6 in its bits 6:0. Bit 7 of offset 1 is dropped and reads as 0. Both registers read back what was stored.
- R4: With a long type, a read of offset 2 (data lane 0) pulses `mem_re` once at the current word address. It loads the returned word into the staging register and answers with its bits 7:0.
- R5: With a long type, reads of offsets 3, 4 and 5 answer staged bits 15:8, 23:16 and 31:24 and raise no `mem_re`.
- R6: With a long type, writes to offsets 2 to 4 only update the staging lane. A write to offset 5 issues one `mem_we` at the current word address with `mem_be` = 1111 and data {written byte, staged bits 23:0}.
- R7: With type 11, every access to offset 5 (read or write) advances the word address by one after the transfer, and address 8191 wraps to 0. Type 10 never advances the address.
- R8: With type 00 or 01, a read of offset 2+n pulses `mem_re` at the word address and answers bits 8n+7:8n of the returned word. Byte accesses never change the address.
- R9: With type 00 or 01, a write to offset 2+n issues one `mem_we` with only `mem_be` bit n set and the byte on every lane of `mem_wdata`.
- R10: A read that needs memory answers three cycles after acceptance, with `io_ready` low for the two cycles in between. Any other read answers one cycle after acceptance. A write's memory strobe appears in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_base | input | 16 | Port address of window offset 0 |
| io_valid | input | 1 | Host request valid |
| io_ready | output | 1 | Block can accept a request |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host port address |
| io_wdata | input | 8 | Host write byte |
| io_rvalid | output | 1 | Read answer valid (one cycle) |
| io_rdata | output | 8 | Read answer byte |
| mem_addr | output | 13 | Memory word address |
| mem_wdata | output | 32 | Memory write word |
| mem_be | output | 4 | Memory byte enables |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Memory read word, valid one cycle after `mem_re` |

## Verification
The embedded properties watch the following on every cycle:
- `mem_re` and `mem_we` are never high together.
- Byte enables are either a single lane or all four.
- A fetch always yields an answer two cycles later.
- A staged-lane read never touches memory.
- A lane-3 commit carries the full mask and the host's byte.
- An increment moves the address by exactly one.

Only the bench scenarios can show the rest. These are the data values that pass through the staging register, readback of the address registers after streaming and wrap-around, the decode of out-of-window offsets and of a moved base, and the answer latencies seen from the host side.

// File: rtl/hmw_pkg.sv
package hmw_pkg;
  typedef enum logic [1:0] {
    XFER_BYTE     = 2'b00,
    XFER_HALF     = 2'b01,
    XFER_WORD     = 2'b10,
    XFER_WORD_INC = 2'b11
  } xfer_e;

  typedef enum logic [1:0] {
    FSM_IDLE  = 2'd0,
    FSM_FETCH = 2'd1,
    FSM_WAIT  = 2'd2
  } fsm_e;

  localparam int SLOT_COUNT = 6;
  localparam int SLOT_W     = 3;
  localparam int LANE_COUNT = 4;
  localparam int LANE_W     = 2;
endpackage

// File: rtl/hmw_decode.sv
module hmw_decode import hmw_pkg::*; #(
  parameter int IO_AW = 16
) (
  input  logic [IO_AW-1:0]  port_addr,
  input  logic [IO_AW-1:0]  base,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);
  logic [IO_AW-1:0] diff;

  always_comb begin
    diff = port_addr - base;
    hit  = diff < IO_AW'(SLOT_COUNT);
    slot = diff[SLOT_W-1:0];
  end
endmodule

// File: rtl/hmw_addr_reg.sv
module hmw_addr_reg import hmw_pkg::*; #(
  parameter int WORD_AW = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [7:0]         wbyte,
  input  logic               step,
  output logic [WORD_AW-1:0] word_addr,
  output xfer_e              xfer,
  output logic [7:0]         lo_view,
  output logic [7:0]         hi_view
);
  localparam int LO_W = 6;
  localparam int HI_W = WORD_AW - LO_W;

  logic [WORD_AW-1:0] wa;
  xfer_e              mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa     <= '0;
      mode_q <= XFER_BYTE;
    end else if (wr_lo) begin
      wa[LO_W-1:0] <= wbyte[7:2];
      mode_q       <= xfer_e'(wbyte[1:0]);
    end else if (wr_hi) begin
      wa[WORD_AW-1:LO_W] <= wbyte[HI_W-1:0];
    end else if (step) begin
      wa <= wa + 1'b1;
    end
  end

  always_comb begin
    word_addr = wa;
    xfer      = mode_q;
    lo_view   = {wa[LO_W-1:0], mode_q};
    hi_view   = {{(8-HI_W){1'b0}}, wa[WORD_AW-1:LO_W]};
  end

  // R7: each step moves the word address by exactly one, wrapping
  a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_lo && !wr_hi) |=> wa == WORD_AW'($past(wa) + 1'b1));
endmodule

// File: rtl/hmw_stage.sv
module hmw_stage import hmw_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [31:0]           load_word,
  input  logic [LANE_COUNT-1:0] lane_we,
  input  logic [7:0]            lane_byte,
  output logic [31:0]           word
);
  for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word[8*g +: 8] <= '0;
      else if (load)       word[8*g +: 8] <= load_word[8*g +: 8];
      else if (lane_we[g]) word[8*g +: 8] <= lane_byte;
    end
  end
endmodule

// File: rtl/host_mem_window.sv
module host_mem_window import hmw_pkg::*; #(
  parameter int IO_AW   = 16,
  parameter int WORD_AW = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IO_AW-1:0]   win_base,
  input  logic               io_valid,
  output logic               io_ready,
  input  logic               io_write,
  input  logic [IO_AW-1:0]   io_addr,
  input  logic [7:0]         io_wdata,
  output logic               io_rvalid,
  output logic [7:0]         io_rdata,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  output logic [3:0]         mem_be,
  output logic               mem_we,
  output logic               mem_re,
  input  logic [31:0]        mem_rdata
);
  fsm_e               state;
  logic               hit;
  logic [SLOT_W-1:0]  slot;
  logic [LANE_W-1:0]  lane, pend_lane;
  logic               pend_long;
  logic [WORD_AW-1:0] word_addr;
  xfer_e              xfer;
  logic [7:0]         lo_view, hi_view;
  logic [31:0]        staged;
  logic               acc, data_acc, is_long;
  logic               wr_lo, wr_hi, need_fetch, stage_rd, step, flush, bwrite;
  logic [LANE_COUNT-1:0] lane_we;
  logic [7:0]         reg_view;
  logic               rvalid_q, we_q;
  logic [7:0]         rdata_q;
  logic [WORD_AW-1:0] maddr_q;
  logic [31:0]        mwdata_q;
  logic [3:0]         mbe_q;

  hmw_decode #(.IO_AW(IO_AW)) u_decode (
    .port_addr(io_addr), .base(win_base), .hit(hit), .slot(slot)
  );

  hmw_addr_reg #(.WORD_AW(WORD_AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wbyte(io_wdata),
    .step(step), .word_addr(word_addr), .xfer(xfer),
    .lo_view(lo_view), .hi_view(hi_view)
  );

  hmw_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .load(state == FSM_WAIT && pend_long), .load_word(mem_rdata),
    .lane_we(lane_we), .lane_byte(io_wdata), .word(staged)
  );

  always_comb begin
    io_ready   = (state == FSM_IDLE);
    acc        = io_valid && io_ready;
    lane       = LANE_W'(slot - SLOT_W'(2));
    is_long    = xfer[1];
    data_acc   = acc && hit && (slot >= SLOT_W'(2));
    wr_lo      = acc && io_write && hit && (slot == SLOT_W'(0));
    wr_hi      = acc && io_write && hit && (slot == SLOT_W'(1));
    need_fetch = data_acc && !io_write && (!is_long || lane == '0);
    stage_rd   = data_acc && !io_write && is_long && lane != '0;
    step       = data_acc && (xfer == XFER_WORD_INC) && (lane == LANE_W'(3));
    flush      = data_acc && io_write && is_long && (lane == LANE_W'(3));
    bwrite     = data_acc && io_write && !is_long;
    lane_we    = (data_acc && io_write && is_long) ? LANE_COUNT'(1) << lane : '0;
    if (!hit)                     reg_view = 8'h00;
    else if (slot == SLOT_W'(0))  reg_view = lo_view;
    else if (slot == SLOT_W'(1))  reg_view = hi_view;
    else                          reg_view = staged[8*lane +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FSM_IDLE;
      pend_lane <= '0;
      pend_long <= 1'b0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
      we_q      <= 1'b0;
      maddr_q   <= '0;
      mwdata_q  <= '0;
      mbe_q     <= '0;
    end else begin
      rvalid_q <= 1'b0;
      we_q     <= 1'b0;
      case (state)
        FSM_IDLE: begin
          if (need_fetch) begin
            state     <= FSM_FETCH;
            pend_lane <= lane;
            pend_long <= is_long;
            maddr_q   <= word_addr;
          end else if (acc && !io_write) begin
            rvalid_q <= 1'b1;
            rdata_q  <= reg_view;
          end
          if (flush) begin
            we_q     <= 1'b1;
            maddr_q  <= word_addr;
            mwdata_q <= {io_wdata, staged[23:0]};
            mbe_q    <= 4'hF;
          end else if (bwrite) begin
            we_q     <= 1'b1;
            maddr_q  <= word_addr;
            mwdata_q <= {LANE_COUNT{io_wdata}};
            mbe_q    <= 4'(1) << lane;
          end
        end
        FSM_FETCH: state <= FSM_WAIT;
        default: begin
          state    <= FSM_IDLE;
          rvalid_q <= 1'b1;
          rdata_q  <= mem_rdata[8*pend_lane +: 8];
        end
      endcase
    end
  end

  always_comb begin
    io_rvalid = rvalid_q;
    io_rdata  = rdata_q;
    mem_addr  = maddr_q;
    mem_wdata = mwdata_q;
    mem_be    = mbe_q;
    mem_we    = we_q;
    mem_re    = (state == FSM_FETCH);
  end

  // R10: read and write strobes never overlap
  a_r10_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  // R4: a fetch is always answered two cycles after its strobe
  a_r4_fetch_answers: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ##2 io_rvalid);
  // R5: a staged-lane read raises no memory strobe
  a_r5_stage_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    stage_rd |=> !mem_re);
  // R6: a lane-3 commit writes the full word with the host byte on top
  a_r6_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mem_we && mem_be == 4'hF && mem_wdata[31:24] == $past(io_wdata)));
  // R9: enables are a single lane or the whole word
  a_r9_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'hF));
endmodule

// File: tb/host_mem_window_bench.sv
module host_mem_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] win_base = 16'h0800;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_ready, io_rvalid, mem_we, mem_re;
  logic [7:0]  io_rdata;
  logic [12:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  int checks = 0, errors = 0;
  logic [31:0] ram   [64];
  logic [31:0] model [64];
  logic [31:0] rd_q = '0;
  logic        we_seen;
  logic [12:0] we_addr;
  logic [31:0] we_data;
  logic [3:0]  we_be;

  always #10 clk = ~clk;

  host_mem_window u_host_mem_window (
    .clk(clk), .rst_n(rst_n), .win_base(win_base), .io_valid(io_valid),
    .io_ready(io_ready), .io_write(io_write), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_word(int i);
    return (32'(i) * 32'h01020304) ^ 32'hA5C30F1E;
  endfunction

  initial for (int i = 0; i < 64; i++) begin
    ram[i]   = init_word(i);
    model[i] = init_word(i);
  end

  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) ram[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_re) rd_q <= ram[mem_addr[5:0]];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic host(input bit w, input logic [15:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output int lat);
    @(negedge clk);
    io_valid = 1'b1; io_write = w; io_addr = a; io_wdata = d;
    while (!io_ready) @(negedge clk);
    @(posedge clk);
    lat = 0; rd = 8'hXX;
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        io_valid = 1'b0;
        we_seen = mem_we; we_addr = mem_addr; we_data = mem_wdata; we_be = mem_be;
      end
      if (w) break;
      if (io_rvalid) begin rd = io_rdata; break; end
      if (lat > 8) break;
    end
  endtask

  task automatic wr(input int off, input logic [7:0] d);
    logic [7:0] rd; int lat;
    host(1'b1, win_base + 16'(off), d, rd, lat);
  endtask

  task automatic rd_at(input int off, output logic [7:0] rd, output int lat);
    host(1'b0, win_base + 16'(off), 8'h00, rd, lat);
  endtask

  task automatic set_addr(input logic [12:0] wa, input logic [1:0] mode);
    wr(0, {wa[5:0], mode});
    wr(1, {1'b0, wa[12:6]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] r; int lat; logic [31:0] w; logic [7:0] bv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(io_ready === 1'b1, "R1 ready", io_ready, 1);
    check(mem_we === 1'b0 && mem_re === 1'b0 && io_rvalid === 1'b0,
          "R1 strobes", {mem_we, mem_re, io_rvalid}, 0);
    rst_n = 1'b1;
    rd_at(0, r, lat); check(r === 8'h00, "R1 addr0", r, 0);
    rd_at(1, r, lat); check(r === 8'h00, "R1 addr1", r, 0);

    // R3 address register storage
    wr(0, 8'hB7); wr(1, 8'hFF);
    rd_at(0, r, lat); check(r === 8'hB7, "R3 addr0 readback", r, 8'hB7);
    rd_at(1, r, lat); check(r === 8'h7F, "R3 addr1 bit7 dropped", r, 8'h7F);
    check(lat == 1, "R10 register read latency", lat, 1);

    // R2 decode sweep around the window
    for (int off = -3; off < 10; off++) begin
      if (off < 0 || off > 5) begin
        rd_at(off, r, lat);
        check(r === 8'h00 && lat == 1, "R2 outside read", {r, 8'(lat)}, 8'h01);
        wr(off, 8'hFF);
        check(we_seen === 1'b0, "R2 outside write no strobe", we_seen, 0);
      end
    end
    rd_at(0, r, lat); check(r === 8'hB7, "R2 addr0 untouched", r, 8'hB7);
    rd_at(1, r, lat); check(r === 8'h7F, "R2 addr1 untouched", r, 8'h7F);

    // R4 R5 R7 long auto-increment read stream of words 5..7
    set_addr(13'd5, 2'b11);
    for (int k = 0; k < 3; k++) begin
      w = model[5 + k];
      for (int ln = 0; ln < 4; ln++) begin
        rd_at(2 + ln, r, lat);
        if (ln == 0) begin
          check(r === w[7:0], "R4 fetch lane0", r, w[7:0]);
          check(lat == 3, "R10 fetch latency", lat, 3);
        end else begin
          check(r === w[8*ln +: 8], "R5 staged lane", r, w[8*ln +: 8]);
          check(lat == 1, "R5 staged latency", lat, 1);
        end
      end
    end
    rd_at(0, r, lat); check(r === 8'h23, "R7 stream advanced to 8", r, 8'h23);

    // R6 R7 long auto-increment write of words 20, 21
    set_addr(13'd20, 2'b11);
    for (int k = 0; k < 2; k++) begin
      w = 32'h13579BDF ^ (32'(k) * 32'h01010101);
      for (int ln = 0; ln < 4; ln++) begin
        wr(2 + ln, w[8*ln +: 8]);
        if (ln < 3) check(we_seen === 1'b0, "R6 staging only", we_seen, 0);
        else begin
          check(we_seen === 1'b1 && we_be === 4'hF, "R6 commit enables",
                we_be, 4'hF);
          check(we_data === w, "R6 commit data", we_data, w);
          check(we_addr === 13'(20 + k), "R6 commit address", we_addr, 20 + k);
        end
      end
      model[20 + k] = w;
    end
    // R7 type 10 reads word 20 twice without moving
    set_addr(13'd20, 2'b10);
    for (int pass = 0; pass < 2; pass++)
      for (int ln = 0; ln < 4; ln++) begin
        rd_at(2 + ln, r, lat);
        check(r === model[20][8*ln +: 8], "R7 no-step readback", r,
              model[20][8*ln +: 8]);
      end
    rd_at(0, r, lat); check(r === 8'h52, "R7 type 10 holds address", r, 8'h52);

    // R7 wrap at the top of the address space
    set_addr(13'd8191, 2'b11);
    for (int ln = 0; ln < 4; ln++) wr(2 + ln, 8'h60 + 8'(ln));
    check(we_addr === 13'd8191, "R7 wrap commit address", we_addr, 8191);
    model[63] = 32'h63626160;
    rd_at(0, r, lat); check(r === 8'h03, "R7 wrap addr0", r, 8'h03);
    rd_at(1, r, lat); check(r === 8'h00, "R7 wrap addr1", r, 8'h00);

    // R8 R9 byte modes 00 and 01 on word 33
    for (int m = 0; m < 2; m++) begin
      set_addr(13'd33, 2'(m));
      for (int ln = 0; ln < 4; ln++) begin
        bv = 8'h40 + 8'(ln) + 8'(m * 16);
        wr(2 + ln, bv);
        check(we_seen === 1'b1 && we_be === 4'(1 << ln), "R9 one-lane enable",
              we_be, 1 << ln);
        check(we_data[8*ln +: 8] === bv && we_addr === 13'd33, "R9 lane data",
              we_data[8*ln +: 8], bv);
        model[33][8*ln +: 8] = bv;
      end
      for (int ln = 3; ln >= 0; ln--) begin
        rd_at(2 + ln, r, lat);
        check(r === model[33][8*ln +: 8] && lat == 3, "R8 byte read",
              r, model[33][8*ln +: 8]);
      end
      rd_at(0, r, lat);
      check(r === {6'd33, 2'(m)}, "R8 byte mode keeps address", r, {6'd33, 2'(m)});
    end

    // R2 moving the base
    @(negedge clk); win_base = 16'h0300;
    host(1'b0, 16'h0800, 8'h00, r, lat);
    check(r === 8'h00, "R2 old base dead", r, 0);
    rd_at(0, r, lat); check(r === 8'h85, "R2 new base live", r, 8'h85);

    finish_run();
  end
endmodule